// File: doc/BRIEF.md
# Cache Line Refill Engine

This block sits between a cache controller and a Wishbone master port and performs read-only bus traffic for the cache. When the controller reports a miss, the engine fetches a whole line of `WORDS` words. The first word comes from the line-aligned base address and each later word from the next word address. When the controller asks for an uncached access, the engine performs a single-word read at the word-aligned address. Each returned word is handed straight to the cache with its position in the line. A completion pulse accompanies the last word of a line. An error response ends the transfer early and raises an error pulse instead.

The parameter `FAST_MODE` selects one of two bus timings at build time. The conservative timing (0) drops strobe for one cycle after every acknowledged beat, so each line word costs two clocks. It also spends one recovery clock with cycle deasserted after every transfer. The fast timing (1) keeps strobe high across the burst, so a memory that acknowledges every clock returns the line on consecutive clocks. There is no recovery clock in this mode.

Top module: `refill_engine`

## Requirements
- R1: In idle, a miss request is accepted on the clock edge where it is seen. From the next cycle, `wb_cyc`, `wb_stb` and `busy` are 1 and `wb_adr` holds the request address with its low `log2(WORDS)+log2(DW/8)` bits cleared. If a miss and a single request arrive together, the miss wins.
- R2: A line fill delivers exactly `WORDS` words. `word_idx` runs 0,1,2,3 in fetch order. `wb_adr` rises by `DW/8` after each acknowledged beat.
- R3: In conservative timing, after each non-final line beat `wb_stb` is 0 for exactly one cycle while `wb_cyc` stays 1. With a memory that acknowledges at once, the words arrive 1, 3, 5 and 7 cycles after the request cycle.
- R4: In conservative timing, every transfer ends with one cycle of `wb_cyc`=0 and `busy`=1. A single read with an immediate acknowledge is back in idle 3 cycles after the request cycle.
- R5: In fast timing, `wb_stb` stays 1 between line beats. Immediate acknowledges give words 1, 2, 3 and 4 cycles after the request cycle. A single wait cycle on the first beat shifts the words to 2 through 5.
- R6: In fast timing, a single read with an immediate acknowledge returns its word 1 cycle after the request cycle and is idle the cycle after that.
- R7: `line_done` is 1 only together with the last word of a line, where `word_line`=1 and `word_idx`=`WORDS-1`. A single read returns one word with `word_line`=0, `word_idx`=0 and never raises `line_done`.
- R8: An error response while strobe is high raises `xfer_err` in that cycle. `wb_cyc` and `wb_stb` are 0 on the next cycle, `line_done` is not raised, and the next request is served normally.
- R9: Requests seen while `busy`=1 are ignored. They neither alter the running fill nor start another transfer afterwards.
- R10: `wb_stb` is never 1 without `wb_cyc`. While strobe waits for a response, `wb_adr` and `wb_stb` hold.
- R11: `word_data` equals `wb_dat_i` in every cycle where `word_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_req | input | 1 | Line fill request from the cache controller |
| miss_addr | input | AW | Any byte address inside the missing line |
| single_req | input | 1 | Uncached single-word read request |
| single_addr | input | AW | Byte address of the single read |
| wb_ack | input | 1 | Bus acknowledge |
| wb_err | input | 1 | Bus error response |
| wb_dat_i | input | DW | Bus read data |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_adr | output | AW | Bus byte address |
| word_valid | output | 1 | A word is returned this cycle |
| word_idx | output | IDX_W | Position of the returned word in the line |
| word_line | output | 1 | Returned word belongs to a line fill |
| word_data | output | DW | Returned word |
| line_done | output | 1 | Line fill completes this cycle |
| xfer_err | output | 1 | Transfer aborted by an error response |
| busy | output | 1 | Engine is not idle and accepts no request |

## Verification
The assertions watch the protocol invariants on every cycle. They check that strobe implies cycle and that address and strobe hold during a wait. They check the address step and the strobe gap or hold after each beat, the bus release after an error, and that completion comes only with the last indexed word. What the bench scenarios alone can show is the count of cycles from a request to each word and to idle in both timings, and the line-aligned start address. They also show that a miss wins over a simultaneous single read, that requests poked while busy leave no trace, and that a fresh fill works after an error.

// File: rtl/refill_pkg.sv
package refill_pkg;

   // Controller states; GAP and REST are only entered in conservative timing.
   typedef enum logic [2:0] {
      RF_IDLE   = 3'd0,
      RF_LINE   = 3'd1,
      RF_SINGLE = 3'd2,
      RF_GAP    = 3'd3,
      RF_REST   = 3'd4
   } rf_state_e;

   // Number of low address bits covered by one data word.
   function automatic int unsigned byte_bits(input int unsigned dw);
      return $clog2(dw / 8);
   endfunction

endpackage

// File: rtl/refill_addr_gen.sv
module refill_addr_gen #(
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned WORDS = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_line,
   input  logic          load_single,
   input  logic [AW-1:0] req_addr,
   input  logic          step,
   output logic [AW-1:0] adr
);
   import refill_pkg::*;

   localparam int unsigned BYTES    = DW / 8;
   localparam int unsigned BYTE_OFF = byte_bits(DW);
   localparam int unsigned LINE_OFF = BYTE_OFF + $clog2(WORDS);
   localparam logic [AW-1:0] LINE_MASK = {{(AW-LINE_OFF){1'b1}}, {LINE_OFF{1'b0}}};
   localparam logic [AW-1:0] WORD_MASK = {{(AW-BYTE_OFF){1'b1}}, {BYTE_OFF{1'b0}}};
   localparam logic [AW-1:0] STRIDE    = AW'(BYTES);

   logic [AW-1:0] adr_q;

   // A line starts at its aligned base; a single read at its aligned word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adr_q <= '0;
      end else if (load_line) begin
         adr_q <= req_addr & LINE_MASK;
      end else if (load_single) begin
         adr_q <= req_addr & WORD_MASK;
      end else if (step) begin
         adr_q <= adr_q + STRIDE;
      end
   end

   assign adr = adr_q;

endmodule

// File: rtl/refill_beat_ctr.sv
module refill_beat_ctr #(
   parameter int unsigned WORDS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       step,
   output logic [$clog2(WORDS)-1:0]   idx,
   output logic                       last
);
   localparam int unsigned IDX_W = $clog2(WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   logic [IDX_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + IDX_W'(1);
      end
   end

   assign idx  = cnt_q;
   assign last = (cnt_q == LAST_IDX);

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
   parameter bit FAST_MODE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic miss_req,
   input  logic single_req,
   input  logic beat,
   input  logic bus_err,
   input  logic last,
   output logic load_line,
   output logic load_single,
   output logic cyc,
   output logic stb,
   output logic in_line,
   output logic busy
);
   import refill_pkg::*;

   rf_state_e st_q, st_d;
   rf_state_e after_beat;   // state following a non-final line beat
   rf_state_e after_end;    // state following the end of any transfer

   // Timing variant: conservative drops strobe between beats and rests after
   // each transfer; fast keeps strobe up and returns straight to idle.
   generate
      if (FAST_MODE) begin : g_fast
         assign after_beat = RF_LINE;
         assign after_end  = RF_IDLE;
      end else begin : g_slow
         assign after_beat = RF_GAP;
         assign after_end  = RF_REST;
      end
   endgenerate

   always_comb begin
      st_d        = st_q;
      load_line   = 1'b0;
      load_single = 1'b0;
      unique case (st_q)
         RF_IDLE: begin
            if (miss_req) begin
               load_line = 1'b1;
               st_d      = RF_LINE;
            end else if (single_req) begin
               load_single = 1'b1;
               st_d        = RF_SINGLE;
            end
         end
         RF_LINE: begin
            if (bus_err) begin
               st_d = after_end;
            end else if (beat) begin
               st_d = last ? after_end : after_beat;
            end
         end
         RF_SINGLE: begin
            if (bus_err || beat) begin
               st_d = after_end;
            end
         end
         RF_GAP:  st_d = RF_LINE;
         RF_REST: st_d = RF_IDLE;
         default: st_d = RF_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= RF_IDLE;
      end else begin
         st_q <= st_d;
      end
   end

   assign stb     = (st_q == RF_LINE) || (st_q == RF_SINGLE);
   assign cyc     = stb || (st_q == RF_GAP);
   assign in_line = (st_q == RF_LINE) || (st_q == RF_GAP);
   assign busy    = (st_q != RF_IDLE);

endmodule

// File: rtl/refill_engine.sv
module refill_engine #(
   parameter int unsigned AW        = 32,
   parameter int unsigned DW        = 32,
   parameter int unsigned WORDS     = 4,
   parameter bit          FAST_MODE = 1'b0,
   localparam int unsigned IDX_W    = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_req,
   input  logic [AW-1:0]    miss_addr,
   input  logic             single_req,
   input  logic [AW-1:0]    single_addr,
   input  logic             wb_ack,
   input  logic             wb_err,
   input  logic [DW-1:0]    wb_dat_i,
   output logic             wb_cyc,
   output logic             wb_stb,
   output logic [AW-1:0]    wb_adr,
   output logic             word_valid,
   output logic [IDX_W-1:0] word_idx,
   output logic             word_line,
   output logic [DW-1:0]    word_data,
   output logic             line_done,
   output logic             xfer_err,
   output logic             busy
);

   // Elaboration-time parameter checks.
   generate
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("refill_engine: WORDS must be a power of two of at least 2");
      end
      if (DW < 8 || (DW & (DW - 1)) != 0) begin : g_bad_dw
         $error("refill_engine: DW must be a power of two of at least 8");
      end
      if (AW <= IDX_W + $clog2(DW / 8)) begin : g_bad_aw
         $error("refill_engine: AW too narrow for one line");
      end
   endgenerate

   logic load_line, load_single, in_line, last, beat, bus_err;
   logic [AW-1:0] req_addr;

   // A beat is an acknowledged strobe that is not also an error.
   assign beat    = wb_stb & wb_ack & ~wb_err;
   assign bus_err = wb_stb & wb_err;
   assign req_addr = miss_req ? miss_addr : single_addr;

   refill_ctrl #(
      .FAST_MODE (FAST_MODE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .miss_req    (miss_req),
      .single_req  (single_req),
      .beat        (beat),
      .bus_err     (bus_err),
      .last        (last),
      .load_line   (load_line),
      .load_single (load_single),
      .cyc         (wb_cyc),
      .stb         (wb_stb),
      .in_line     (in_line),
      .busy        (busy)
   );

   refill_addr_gen #(
      .AW    (AW),
      .DW    (DW),
      .WORDS (WORDS)
   ) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_line   (load_line),
      .load_single (load_single),
      .req_addr    (req_addr),
      .step        (beat & in_line),
      .adr         (wb_adr)
   );

   refill_beat_ctr #(
      .WORDS (WORDS)
   ) u_beat (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (load_line | load_single),
      .step  (beat & in_line),
      .idx   (word_idx),
      .last  (last)
   );

   assign word_valid = beat;
   assign word_line  = in_line;
   assign word_data  = wb_dat_i;
   assign line_done  = beat & in_line & last;
   assign xfer_err   = bus_err;

endmodule

// File: rtl/refill_engine_chk.sv
module refill_engine_chk #(
   parameter int unsigned AW        = 32,
   parameter int unsigned DW        = 32,
   parameter int unsigned WORDS     = 4,
   parameter bit          FAST_MODE = 1'b0,
   localparam int unsigned IDX_W    = $clog2(WORDS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wb_ack,
   input logic             wb_err,
   input logic             wb_cyc,
   input logic             wb_stb,
   input logic [AW-1:0]    wb_adr,
   input logic             word_valid,
   input logic [IDX_W-1:0] word_idx,
   input logic             word_line,
   input logic             line_done,
   input logic             xfer_err,
   input logic             busy
);
   localparam logic [AW-1:0]    STRIDE   = AW'(DW / 8);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   // R10
   stb_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_stb |-> wb_cyc);

   // R10
   adr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_stb && !wb_ack && !wb_err) |=> (wb_stb && $stable(wb_adr)));

   // R8
   err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |=> (!wb_cyc && !wb_stb));

   // R7
   done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> (word_valid && word_line && word_idx == LAST_IDX));

   // R7
   single_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && !word_line) |-> (!line_done && word_idx == '0));

   // R2
   adr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_line && !line_done) |=> (wb_adr == $past(wb_adr) + STRIDE));

   // R2
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word_line && !line_done) |=> (word_idx == $past(word_idx) + IDX_W'(1)));

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_cyc) |-> !$past(busy));

   generate
      if (FAST_MODE) begin : g_fast
         // R5
         burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (word_valid && word_line && !line_done) |=> wb_stb);
         // R6
         no_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wb_cyc) |-> !busy);
      end else begin : g_slow
         // R3
         beat_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (word_valid && word_line && !line_done) |=> (wb_cyc && !wb_stb));
         // R4
         rest_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(wb_cyc) |-> busy);
      end
   endgenerate

endmodule

bind refill_engine refill_engine_chk #(
   .AW        (AW),
   .DW        (DW),
   .WORDS     (WORDS),
   .FAST_MODE (FAST_MODE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wb_ack     (wb_ack),
   .wb_err     (wb_err),
   .wb_cyc     (wb_cyc),
   .wb_stb     (wb_stb),
   .wb_adr     (wb_adr),
   .word_valid (word_valid),
   .word_idx   (word_idx),
   .word_line  (word_line),
   .line_done  (line_done),
   .xfer_err   (xfer_err),
   .busy       (busy)
);

// File: tb/refill_engine_tb.sv
module refill_engine_tb;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz
   logic rst_n;

   // index 0: conservative timing (u_dut), index 1: fast timing (u_dut_fast)
   logic        mreq [2];
   logic        sreq [2];
   logic [31:0] maddr[2];
   logic [31:0] saddr[2];
   logic        cyc[2], stb[2], ack[2], err[2], wv[2], wl[2], done[2], xerr[2], busy[2];
   logic [31:0] adr[2], rdat[2], wdat[2];
   logic [1:0]  widx[2];
   logic        rdy[2], ef[2];

   for (genvar g = 0; g < 2; g++) begin : g_mem
      assign ack[g]  = stb[g] & rdy[g] & ~ef[g];
      assign err[g]  = stb[g] & ef[g];
      assign rdat[g] = {adr[g][15:0], ~adr[g][15:0]};
   end

   refill_engine #(.FAST_MODE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .miss_req(mreq[0]), .miss_addr(maddr[0]),
      .single_req(sreq[0]), .single_addr(saddr[0]), .wb_ack(ack[0]), .wb_err(err[0]),
      .wb_dat_i(rdat[0]), .wb_cyc(cyc[0]), .wb_stb(stb[0]), .wb_adr(adr[0]),
      .word_valid(wv[0]), .word_idx(widx[0]), .word_line(wl[0]), .word_data(wdat[0]),
      .line_done(done[0]), .xfer_err(xerr[0]), .busy(busy[0]));

   refill_engine #(.FAST_MODE(1'b1)) u_dut_fast (
      .clk(clk), .rst_n(rst_n), .miss_req(mreq[1]), .miss_addr(maddr[1]),
      .single_req(sreq[1]), .single_addr(saddr[1]), .wb_ack(ack[1]), .wb_err(err[1]),
      .wb_dat_i(rdat[1]), .wb_cyc(cyc[1]), .wb_stb(stb[1]), .wb_adr(adr[1]),
      .word_valid(wv[1]), .word_idx(widx[1]), .word_line(wl[1]), .word_data(wdat[1]),
      .line_done(done[1]), .xfer_err(xerr[1]), .busy(busy[1]));

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Record of one transfer; n counts negedges after the request cycle.
   int          nw, nd, done_n, ne, err_n, ngap, cyc_post_err, idle_n, stb_nocyc;
   int          cyc2, busy2;
   int          r_idx[8], r_n[8];
   logic [31:0] r_adr[8], r_dat[8], r_bus[8], wait_adr;
   bit          r_line[8];

   task automatic run(input int d, input bit line, input logic [31:0] a, input int wait_n,
                      input int err_beat, input bit poke, input bit both);
      bit prev_err;
      nw = 0; nd = 0; done_n = -1; ne = 0; err_n = -1; ngap = 0; cyc_post_err = -1;
      idle_n = -1; stb_nocyc = 0; cyc2 = -1; busy2 = -1; wait_adr = '0; prev_err = 1'b0;
      @(negedge clk);
      if (line) begin mreq[d] = 1'b1; maddr[d] = a; end
      if (!line || both) begin sreq[d] = 1'b1; saddr[d] = both ? 32'h2000_0000 : a; end
      rdy[d] = 1'b0; ef[d] = 1'b0;
      for (int n = 1; n <= 40; n++) begin
         @(negedge clk);
         mreq[d] = 1'b0; sreq[d] = 1'b0;
         if (poke && n == 2) begin
            mreq[d] = 1'b1; sreq[d] = 1'b1; maddr[d] = 32'hFFFF_FF00; saddr[d] = 32'hFFFF_FF00;
         end
         rdy[d] = (n > wait_n);
         ef[d]  = (err_beat >= 0) && (nw == err_beat) && (ne == 0);
         #1;
         if (prev_err) cyc_post_err = int'(cyc[d]);
         prev_err = xerr[d];
         if (n == 2) begin cyc2 = int'(cyc[d]); busy2 = int'(busy[d]); end
         if (stb[d] && !cyc[d]) stb_nocyc++;
         if (cyc[d] && !stb[d]) ngap++;
         if (stb[d] && !ack[d] && !err[d]) wait_adr = adr[d];
         if (wv[d] && nw < 8) begin
            r_n[nw] = n; r_idx[nw] = int'(widx[nw >= 0 ? d : d]); r_adr[nw] = adr[d];
            r_dat[nw] = wdat[d]; r_bus[nw] = rdat[d]; r_line[nw] = wl[d];
            nw++;
         end
         if (done[d]) begin nd++; done_n = n; end
         if (xerr[d]) begin ne++; err_n = n; end
         if (!busy[d]) begin idle_n = n; break; end
      end
      rdy[d] = 1'b0; ef[d] = 1'b0; mreq[d] = 1'b0; sreq[d] = 1'b0;
   endtask

   task automatic check_line(input string req, input logic [31:0] base, input int first,
                             input int step, input int gaps);
      int last_n;
      last_n = first + 3 * step;
      chk(nw == 4, "R2", "word count", nw, 4);
      for (int i = 0; i < 4 && i < nw; i++) begin
         chk(r_idx[i] == i, "R2", "word_idx order", r_idx[i], i);
         chk(r_adr[i] == base + 32'(4 * i), "R2", "beat address", r_adr[i], base + 32'(4 * i));
         chk(r_dat[i] == r_bus[i], "R11", "word_data", r_dat[i], r_bus[i]);
         chk(r_line[i] == 1'b1, "R7", "word_line on fill", r_line[i], 1);
         chk(r_n[i] == first + i * step, req, "word cycle", r_n[i], first + i * step);
      end
      chk(nd == 1 && done_n == last_n, "R7", "line_done cycle", done_n, last_n);
      chk(ngap == gaps, req, "strobe gap cycles", ngap, gaps);
      chk(stb_nocyc == 0, "R10", "stb without cyc", stb_nocyc, 0);
   endtask

   task automatic expect_quiet(input int d, input string req);
      @(negedge clk); #1;
      chk(!cyc[d] && !busy[d], req, "no transfer after idle", int'(cyc[d]), 0);
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      for (int d = 0; d < 2; d++) begin
         chk(!cyc[d] && !stb[d] && !busy[d], "R1", "reset bus idle", int'(cyc[d]) + int'(stb[d]), 0);
         chk(!wv[d] && !done[d] && !xerr[d], "R7", "reset outputs", int'(wv[d]), 0);
      end
   endtask

   task automatic t_slow_line();
      run(0, 1'b1, 32'h1000_0034, 0, -1, 1'b0, 1'b0);
      check_line("R3", 32'h1000_0030, 1, 2, 3);
      chk(idle_n == 9, "R4", "slow line idle cycle", idle_n, 9);
   endtask

   task automatic t_slow_single();
      run(0, 1'b0, 32'h0000_0A06, 0, -1, 1'b0, 1'b0);
      chk(nw == 1 && r_n[0] == 1, "R4", "slow single word cycle", r_n[0], 1);
      chk(r_adr[0] == 32'h0000_0A04, "R4", "single word address", r_adr[0], 32'h0000_0A04);
      chk(!r_line[0] && r_idx[0] == 0 && nd == 0, "R7", "single flags", nd, 0);
      chk(cyc2 == 0 && busy2 == 1, "R4", "rest cycle cyc/busy", cyc2, 0);
      chk(idle_n == 3, "R4", "slow single idle cycle", idle_n, 3);
   endtask

   task automatic t_fast_line();
      run(1, 1'b1, 32'h2000_004C, 0, -1, 1'b0, 1'b0);
      check_line("R5", 32'h2000_0040, 1, 1, 0);
      chk(idle_n == 5, "R5", "fast line idle cycle", idle_n, 5);
   endtask

   task automatic t_fast_wait();
      run(1, 1'b1, 32'h2100_0000, 1, -1, 1'b0, 1'b0);
      check_line("R5", 32'h2100_0000, 2, 1, 0);
      chk(wait_adr == 32'h2100_0000, "R10", "address held in wait", wait_adr, 32'h2100_0000);
      chk(idle_n == 6, "R5", "fast waited line idle cycle", idle_n, 6);
   endtask

   task automatic t_fast_single();
      run(1, 1'b0, 32'h0000_1230, 0, -1, 1'b0, 1'b0);
      chk(nw == 1 && r_n[0] == 1, "R6", "fast single word cycle", r_n[0], 1);
      chk(r_dat[0] == r_bus[0], "R11", "single data", r_dat[0], r_bus[0]);
      chk(!r_line[0] && nd == 0, "R7", "fast single no done", nd, 0);
      chk(idle_n == 2, "R6", "fast single idle cycle", idle_n, 2);
   endtask

   task automatic t_priority();
      run(0, 1'b1, 32'h3000_0010, 0, -1, 1'b0, 1'b1);
      check_line("R1", 32'h3000_0010, 1, 2, 3);
      expect_quiet(0, "R1");
   endtask

   task automatic t_busy_ignore();
      for (int d = 0; d < 2; d++) begin
         run(d, 1'b1, 32'h4000_0020, 0, -1, 1'b1, 1'b0);
         check_line("R9", 32'h4000_0020, 1, d == 0 ? 2 : 1, d == 0 ? 3 : 0);
         expect_quiet(d, "R9");
      end
   endtask

   task automatic t_error();
      run(0, 1'b1, 32'h5000_0000, 0, 2, 1'b0, 1'b0);
      chk(nw == 2 && ne == 1 && err_n == 5, "R8", "slow error cycle", err_n, 5);
      chk(cyc_post_err == 0, "R8", "slow cyc after error", cyc_post_err, 0);
      chk(nd == 0 && idle_n == 7, "R8", "slow error no done / idle", idle_n, 7);
      run(0, 1'b1, 32'h5000_0100, 0, -1, 1'b0, 1'b0);
      check_line("R8", 32'h5000_0100, 1, 2, 3);
      run(1, 1'b1, 32'h6000_0000, 0, 2, 1'b0, 1'b0);
      chk(nw == 2 && ne == 1 && err_n == 3, "R8", "fast error cycle", err_n, 3);
      chk(cyc_post_err == 0 && nd == 0, "R8", "fast cyc after error", cyc_post_err, 0);
      chk(idle_n == 4, "R8", "fast error idle", idle_n, 4);
      run(1, 1'b0, 32'h6000_0008, 0, 0, 1'b0, 1'b0);
      chk(nw == 0 && ne == 1 && err_n == 1 && idle_n == 2, "R8", "fast single error", err_n, 1);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         mreq[d] = 1'b0; sreq[d] = 1'b0; maddr[d] = '0; saddr[d] = '0;
         rdy[d] = 1'b0; ef[d] = 1'b0;
      end
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_slow_line();
      t_slow_single();
      t_fast_line();
      t_fast_wait();
      t_fast_single();
      t_priority();
      t_busy_ignore();
      t_error();
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
   end

endmodule